// File: doc/BRIEF.md
# Dock Instruction Queue with Queue-Control Opcodes

This block holds the instructions waiting to run at one dock. A 26-bit instruction word is taken in over a valid/ready handshake into a single arrival register. From there it enters a small circular queue. The oldest queued word moves into a head register, which offers it to the execute side. The execute side completes a pass with a handshake and reports whether the instruction should reloop. A relooping instruction is written back, unchanged, to the tail of the queue.

Four control opcodes act on the queue itself rather than being executed. An interrupt waits at the arrival register until the head holds an interruptible instruction. It then cancels that pass, although the cancelled instruction may still reloop. A massacre waits for the same condition and then discards everything queued. A clog is queued like any other word, and once it reaches the head it blocks issue. An unclog waits at the arrival register until a clog sits at the head, and then both retire together.

Top module: `dock_insn_queue`

## Requirements
- R1: While `rst` is high at a clock edge, all stages empty: after that edge `in_ready` is 1 and `ex_valid` is 0.
- R2: The arrival register holds one word. From the cycle after a word is accepted, `in_ready` stays 0 until that word leaves the arrival register.
- R3: An instruction is a control opcode when bits 21:18 are 0001. All other words are ordinary. Ordinary words and clogs are queued in arrival order. An ordinary word accepted at edge k into an empty block raises `ex_valid` after edge k+2, and ordinary words reach `ex_insn` in the order they arrived.
- R4: While `ex_valid` is 1 and no pass completes, `ex_insn` holds its value.
- R5: An interrupt (bits 21:16 = 000100) waits in the arrival register until the head holds a non-clog word with bit 25 set that has not already been cancelled. In that cycle `ex_valid` drops. After the next edge, the same word is offered again with `ex_kill` = 1, and the arrival register is free.
- R6: A massacre (bits 21:16 = 000101) waits under the same condition as an interrupt. In that cycle `ex_valid` drops. At the next edge the head, the whole queue and the massacre itself are discarded.
- R7: A clog (bits 21:16 = 000110) at the head keeps `ex_valid` at 0, and no queued word behind it issues.
- R8: An unclog (bits 21:16 = 000111) waits in the arrival register until a clog is at the head. At the next edge both retire, and the next queued word is offered one edge later. An unclog with no clog ever reaching the head stalls the input forever.
- R9: A pass completes (`ex_accept` = 1) when `ex_valid` and `ex_ready` are both 1, unless a reloop is refused (R10). When such a pass has `ex_reloop` = 1, the head word is written back unchanged to the queue tail and is offered again after the words queued ahead of it. A pass cancelled by an interrupt may also reloop this way, and when it comes back it is offered with `ex_kill` = 0.
- R10: With the queue holding DEPTH entries, a reloop request is refused (`ex_accept` = 0). A pass without reloop still completes.
- R11: Interrupt and massacre never match a head word with bit 25 clear: that word keeps `ex_valid` high with `ex_kill` = 0 and completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Arrival register free |
| in_insn | input | 26 | Incoming instruction word |
| ex_valid | output | 1 | Head word offered for a pass |
| ex_ready | input | 1 | Execute side completes the pass this cycle |
| ex_insn | output | 26 | Head instruction word |
| ex_kill | output | 1 | Pass cancelled by interrupt: report reloop only |
| ex_reloop | input | 1 | Reloop decision for the completing pass |
| ex_accept | output | 1 | Pass completed this cycle |

## Verification
An ordinary word accepted at edge k into an empty block reaches the queue at edge k+1 and the head at edge k+2. The bench samples `ex_valid` at the falling edge after each of those edges. A control opcode that matches has a combinational effect: `ex_valid` drops in the cycle after the opcode is accepted. Its register effect (kill flag set, flush, or pair retirement) becomes visible one edge later, and each control test checks both points at falling edges. `ex_accept` is combinational, so it is sampled shortly after `ex_ready` and `ex_reloop` are driven, before the edge that completes the pass. Ordering checks wait for `ex_valid` within a bounded number of cycles and then compare the word.

// File: rtl/dock_insn_queue.sv
module dock_insn_queue #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [25:0] in_insn,
  output logic        ex_valid,
  input  logic        ex_ready,
  output logic [25:0] ex_insn,
  output logic        ex_kill,
  input  logic        ex_reloop,
  output logic        ex_accept
);
  localparam int IW = 26;
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [IW-1:0] ih_q, od_q;
  logic          ih_v, od_v, od_kill;
  logic [IW-1:0] mem [DEPTH];
  logic [PW-1:0] hd, tl;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire ih_ctl  = ih_q[21:18] == 4'b0001;
  wire ih_int  = ih_v && ih_ctl && ih_q[17:16] == 2'b00;
  wire ih_mas  = ih_v && ih_ctl && ih_q[17:16] == 2'b01;
  wire ih_unc  = ih_v && ih_ctl && ih_q[17:16] == 2'b11;
  wire od_clog = od_v && od_q[21:16] == 6'b000110;
  wire od_im   = od_v && od_q[25] && !od_clog && !od_kill;
  wire int_hit = ih_int && od_im;
  wire mas_hit = ih_mas && od_im;
  wire unc_hit = ih_unc && od_clog;
  wire full    = cnt == CW'(DEPTH);

  assign in_ready  = !ih_v;
  assign ex_valid  = od_v && !od_clog && !int_hit && !mas_hit;
  assign ex_insn   = od_q;
  assign ex_kill   = od_kill;
  assign ex_accept = ex_valid && ex_ready && !(ex_reloop && full);

  wire wb      = ex_accept && ex_reloop;
  wire pop     = !od_v && cnt != '0;
  wire push_ih = ih_v && !ih_int && !ih_mas && !ih_unc && !full && !wb;
  wire push    = push_ih || wb;

  always_ff @(posedge clk) begin
    if (rst || mas_hit) begin
      ih_v    <= 1'b0;
      od_v    <= 1'b0;
      od_kill <= 1'b0;
      hd      <= '0;
      tl      <= '0;
      cnt     <= '0;
    end else begin
      if (in_valid && in_ready) begin
        ih_v <= 1'b1;
        ih_q <= in_insn;
      end else if (push_ih || int_hit || unc_hit) begin
        ih_v <= 1'b0;
      end
      if (pop) begin
        od_v    <= 1'b1;
        od_q    <= mem[hd];
        od_kill <= 1'b0;
        hd      <= nxt(hd);
      end else if (ex_accept || unc_hit) begin
        od_v    <= 1'b0;
        od_kill <= 1'b0;
      end else if (int_hit) begin
        od_kill <= 1'b1;
      end
      if (push) tl <= nxt(tl);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ih)  mem[tl] <= ih_q;
    else if (wb)  mem[tl] <= od_q;
  end

  p_reset_empty_r1: assert property (@(posedge clk)
    rst |=> (in_ready && !ex_valid));
  p_single_slot_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);
  p_hold_head_r4: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && !ex_accept) |=> $stable(ex_insn));
  p_kill_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (ex_valid && ex_kill && !ex_accept) |=> ex_kill);
  p_flush_r6: assert property (@(posedge clk) disable iff (rst)
    mas_hit |=> (cnt == '0 && !ex_valid && in_ready));
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
endmodule

// File: tb/dock_insn_queue_bench.sv
module dock_insn_queue_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, ex_ready = 1'b0, ex_reloop = 1'b0;
  logic [25:0] in_insn = '0;
  logic in_ready, ex_valid, ex_kill, ex_accept;
  logic [25:0] ex_insn;
  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dock_insn_queue #(.DEPTH(4)) u_dock_insn_queue (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_insn(in_insn), .ex_valid(ex_valid), .ex_ready(ex_ready),
    .ex_insn(ex_insn), .ex_kill(ex_kill), .ex_reloop(ex_reloop),
    .ex_accept(ex_accept));

  function automatic logic [25:0] ord(input logic im, input logic [7:0] tag);
    return {im, 1'b0, 2'b11, 3'b001, 11'b0, tag};
  endfunction
  function automatic logic [25:0] ctl(input logic [1:0] op);
    return {4'b0, 3'b000, 1'b1, op, 16'b0};
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; in_valid = 1'b0; ex_ready = 1'b0; ex_reloop = 1'b0;
    tick(); tick(); rst = 1'b0;
  endtask

  task automatic put(input logic [25:0] w);
    while (!in_ready) tick();
    in_valid = 1'b1; in_insn = w;
    tick();
    in_valid = 1'b0;
  endtask

  task automatic accept(input logic rl, output logic acc);
    ex_ready = 1'b1; ex_reloop = rl;
    #1 acc = ex_accept;
    tick();
    ex_ready = 1'b0; ex_reloop = 1'b0;
  endtask

  task automatic expect_head(input string req, input logic [25:0] w, input logic k, input logic rl);
    logic acc;
    for (int i = 0; i < 12 && !ex_valid; i++) tick();
    check(req, {ex_valid, ex_kill, 4'b0, ex_insn}, {1'b1, k, 4'b0, w});
    accept(rl, acc);
    check(req, acc, 1);
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 ready", in_ready, 1);
    check("R1 valid", ex_valid, 0);
  endtask

  task automatic t_order();
    do_reset();
    put(ord(0, 8'h11));
    check("R2 busy", in_ready, 0);
    check("R3 k+0", ex_valid, 0);
    tick();
    check("R2 freed", in_ready, 1);
    check("R3 k+1", ex_valid, 0);
    tick();
    check("R3 k+2", ex_valid, 1);
    put(ord(0, 8'h22)); put(ord(0, 8'h33));
    tick(); tick();
    check("R4 held", ex_insn, ord(0, 8'h11));
    expect_head("R3 first", ord(0, 8'h11), 0, 0);
    expect_head("R3 second", ord(0, 8'h22), 0, 0);
    expect_head("R3 third", ord(0, 8'h33), 0, 0);
  endtask

  task automatic t_reloop();
    do_reset();
    put(ord(0, 8'hA1)); put(ord(0, 8'hB2));
    repeat (4) tick();
    expect_head("R9 pass1", ord(0, 8'hA1), 0, 1);
    expect_head("R9 behind", ord(0, 8'hB2), 0, 0);
    expect_head("R9 again", ord(0, 8'hA1), 0, 0);
  endtask

  task automatic t_full();
    logic acc;
    do_reset();
    for (int i = 0; i < 5; i++) put(ord(0, 8'(8'h40 + i)));
    repeat (3) tick();
    check("R10 head", ex_insn, ord(0, 8'h40));
    accept(1, acc);
    check("R10 refused", acc, 0);
    accept(0, acc);
    check("R10 plain", acc, 1);
    for (int i = 1; i < 5; i++) expect_head("R10 drain", ord(0, 8'(8'h40 + i)), 0, 0);
  endtask

  task automatic t_interrupt();
    do_reset();
    put(ord(1, 8'h51));
    repeat (2) tick();
    put(ctl(2'b00));
    check("R5 gated", ex_valid, 0);
    tick();
    check("R5 killed", {ex_valid, ex_kill, in_ready}, 3'b111);
    check("R5 same", ex_insn, ord(1, 8'h51));
    expect_head("R5 reloop", ord(1, 8'h51), 1, 1);
    expect_head("R9 back", ord(1, 8'h51), 0, 0);
  endtask

  task automatic t_no_im();
    do_reset();
    put(ord(0, 8'h61)); put(ord(1, 8'h62));
    repeat (3) tick();
    put(ctl(2'b00));
    repeat (3) tick();
    check("R11 still", {ex_valid, ex_kill, in_ready}, 3'b100);
    expect_head("R11 normal", ord(0, 8'h61), 0, 0);
    expect_head("R5 second", ord(1, 8'h62), 1, 0);
  endtask

  task automatic t_massacre();
    do_reset();
    put(ord(1, 8'h71)); put(ord(0, 8'h72)); put(ord(0, 8'h73));
    repeat (3) tick();
    put(ctl(2'b01));
    check("R6 gated", ex_valid, 0);
    tick();
    check("R6 flushed", {in_ready, ex_valid}, 2'b10);
    repeat (4) tick();
    check("R6 empty", ex_valid, 0);
    put(ord(0, 8'h74));
    expect_head("R6 fresh", ord(0, 8'h74), 0, 0);
  endtask

  task automatic t_clog();
    do_reset();
    put(ctl(2'b10)); put(ord(0, 8'h81));
    repeat (5) tick();
    check("R7 blocked", ex_valid, 0);
    put(ctl(2'b11));
    check("R8 waiting", in_ready, 0);
    tick();
    check("R8 paired", {in_ready, ex_valid}, 2'b10);
    tick();
    check("R8 next", {ex_valid, 4'b0, ex_insn}, {1'b1, 4'b0, ord(0, 8'h81)});
    expect_head("R8 runs", ord(0, 8'h81), 0, 0);
  endtask

  task automatic t_unclog_stall();
    do_reset();
    put(ctl(2'b11));
    repeat (10) tick();
    check("R8 stall", {in_ready, ex_valid}, 2'b00);
  endtask

  initial begin
    t_reset();
    t_order();
    t_reloop();
    t_full();
    t_interrupt();
    t_no_im();
    t_massacre();
    t_clog();
    t_unclog_stall();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      vectors++; miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule